// File: doc/BRIEF.md
# Three-Exposure HDR Radiance Merger

The block takes one color channel of one pixel location as three 8-bit samples: one from a short, one from a medium and one from a long exposure. It turns them into a single 16-bit linear radiance value.

Each sample goes through a fixed camera-response curve that maps a pixel code to log2 exposure. The log2 of that exposure's time is then subtracted, which gives a log2 radiance estimate. A hat-shaped weight trusts mid-scale codes most and distrusts codes near black or near saturation. The three estimates are averaged with those weights. A sequential divider performs the normalisation. A shift-and-mantissa stage then converts the averaged log value back to linear radiance.

Software writes the three log2 exposure times through a small write port before frames are streamed. Pixels are offered with a valid/ready handshake. The block works on one sample triple at a time, and each result appears as a single-cycle valid pulse.

Top module: `hdr_radiance_merge`

## Requirements
- R1: After reset, ready_o is 1, out_valid_o is 0 and out_rad_o is 0. All three stored log exposure times are 0.
- R2: The response curve g maps a pixel code p to log2 exposure in unsigned fixed point with 8 fraction bits. g(p) = 8·p for p < 192, and g(p) = 1536 + 16·(p − 192) otherwise.
- R3: A cycle with cfg_we_i = 1 stores cfg_data_i, a signed value with 8 fraction bits, as the log2 time of one exposure. cfg_sel_i selects the exposure: 0 is short, 1 is medium, 2 is long. cfg_sel_i = 3 changes nothing.
- R4: The weight of a sample p is p when p ≤ 127, and 255 − p otherwise.
- R5: Each log radiance is L_k = g(p_k) − t_k. The merged value is Σw_k·L_k / Σw_k, with the quotient truncated toward zero.
- R6: When all three weights are zero, the merged value is the medium-exposure log radiance L_1.
- R7: The merged log value L is split into n = floor(L/256) and f = L − 256·n. The output is floor((256+f)·2^n / 256), saturated at 65535.
- R8: A triple is accepted on a clock edge where in_valid_i and ready_o are both 1. ready_o is 0 from the next cycle until the result is visible. out_valid_o is a one-cycle pulse, visible exactly 25 clock edges after the accepting edge. While ready_o is 0, in_valid_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for a log exposure time |
| cfg_sel_i | input | 2 | Exposure selected by the write |
| cfg_data_i | input | 12 | Signed log2 exposure time, 8 fraction bits |
| in_valid_i | input | 1 | Sample triple offered |
| px_short_i | input | 8 | Short-exposure sample |
| px_mid_i | input | 8 | Medium-exposure sample |
| px_long_i | input | 8 | Long-exposure sample |
| ready_o | output | 1 | Block can accept a triple |
| out_valid_o | output | 1 | Radiance result valid (one-cycle pulse) |
| out_rad_o | output | 16 | Linear radiance |

## Verification
Some properties are checked on every cycle. The divider remainder must stay below the divisor while the divider runs. ready_o must drop after every acceptance. The result pulse must last one cycle. A non-negative log input to the exponent stage must never produce a zero output.

The rest depends on arithmetic, so only the bench's scenarios can show it. This covers the exact radiance values, the piecewise response curve, the hat weights, truncation of negative quotients toward zero, the all-zero-weight fallback, saturation, the 25-edge latency, the ignored writes to selector 3, and samples offered while busy.

// File: rtl/hdr_merge_pkg.sv
package hdr_merge_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 8;
  localparam int TIME_W = 12;
  localparam int LOG_W  = 14;
  localparam int WGT_W  = PIX_W - 1;
  localparam int WSUM_W = WGT_W + 2;
  localparam int ACC_W  = LOG_W + WGT_W + 3;
  localparam int OUT_W  = 16;
  localparam int N_EXP  = 3;
  localparam int KNEE   = 192;

  // log2 exposure, FRAC_W fraction bits; steeper segment above the knee
  function automatic logic [LOG_W-2:0] cam_curve(input logic [PIX_W-1:0] p);
    if (p < PIX_W'(KNEE)) return (LOG_W-1)'({p, 3'b000});
    return (LOG_W-1)'(KNEE * 8) + (LOG_W-1)'({p - PIX_W'(KNEE), 4'b0000});
  endfunction

  function automatic logic [WGT_W-1:0] hat_wgt(input logic [PIX_W-1:0] p);
    return p[PIX_W-1] ? ~p[WGT_W-1:0] : p[WGT_W-1:0];
  endfunction
endpackage

// File: rtl/hdr_lograd_lane.sv
module hdr_lograd_lane
  import hdr_merge_pkg::*;
(
  input  logic [PIX_W-1:0]         pix_i,
  input  logic signed [TIME_W-1:0] ltime_i,
  output logic signed [LOG_W-1:0]  lrad_o,
  output logic [WGT_W-1:0]         wgt_o,
  output logic signed [ACC_W-1:0]  prod_o
);
  logic [LOG_W-2:0] g_val;

  assign g_val  = cam_curve(pix_i);
  assign wgt_o  = hat_wgt(pix_i);
  assign lrad_o = $signed({1'b0, g_val}) - LOG_W'(ltime_i);
  assign prod_o = ACC_W'(lrad_o) * ACC_W'($signed({1'b0, wgt_o}));
endmodule

// File: rtl/hdr_seq_div.sv
module hdr_seq_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 9,
  parameter int Q_W   = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0]        den_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [Q_W-1:0]   quo_o
);
  localparam int CNT_W = $clog2(NUM_W);

  logic [CNT_W-1:0] cnt;
  logic             neg;
  logic [NUM_W-1:0] quo;
  logic [DEN_W-1:0] rem, den;
  logic [DEN_W:0]   rem_sh;
  logic             fits;
  logic [NUM_W-1:0] mag;

  assign mag    = num_i[NUM_W-1] ? NUM_W'(-num_i) : NUM_W'(num_i);
  assign rem_sh = {rem, quo[NUM_W-1]};
  assign fits   = rem_sh >= {1'b0, den};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
      neg    <= 1'b0;
      quo    <= '0;
      rem    <= '0;
      den    <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      done_o <= 1'b0;
      cnt    <= '0;
      neg    <= num_i[NUM_W-1];
      quo    <= mag;
      rem    <= '0;
      den    <= den_i;
    end else if (busy_o) begin
      rem <= fits ? DEN_W'(rem_sh - {1'b0, den}) : rem_sh[DEN_W-1:0];
      quo <= {quo[NUM_W-2:0], fits};
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(NUM_W - 1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quo_o = neg ? -$signed(quo[Q_W-1:0]) : $signed(quo[Q_W-1:0]);

  // R5
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem < den);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/hdr_exp2.sv
module hdr_exp2 #(
  parameter int LOG_W  = 14,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  logic signed [LOG_W-1:0] l_i,
  output logic                    v_o,
  output logic [OUT_W-1:0]        y_o
);
  localparam int INT_W = LOG_W - FRAC_W;
  localparam int EXT_W = FRAC_W + 1 + OUT_W;

  logic signed [INT_W-1:0] n_int;
  logic [FRAC_W:0]         mant;
  logic [EXT_W-1:0]        big;
  logic [OUT_W-1:0]        y_nx;
  int                      nsh;

  assign n_int = INT_W'(l_i >>> FRAC_W);
  assign mant  = {1'b1, l_i[FRAC_W-1:0]};

  always_comb begin
    nsh  = int'(n_int);
    big  = '0;
    y_nx = '1;
    if (nsh < OUT_W) begin
      if (nsh >= 0) big = (EXT_W'(mant) << nsh) >> FRAC_W;
      else          big = EXT_W'(mant) >> (FRAC_W - nsh);
      y_nx = (|big[EXT_W-1:OUT_W]) ? '1 : big[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      y_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) y_o <= y_nx;
    end
  end

  // R7
  nonneg_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && !l_i[LOG_W-1]) |=> y_o != '0);
endmodule

// File: rtl/hdr_radiance_merge.sv
module hdr_radiance_merge
  import hdr_merge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [TIME_W-1:0] cfg_data_i,
  input  logic              in_valid_i,
  input  logic [PIX_W-1:0]  px_short_i,
  input  logic [PIX_W-1:0]  px_mid_i,
  input  logic [PIX_W-1:0]  px_long_i,
  output logic              ready_o,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_rad_o
);
  logic signed [TIME_W-1:0] ltime [N_EXP];
  logic [PIX_W-1:0]         pix   [N_EXP];
  logic signed [LOG_W-1:0]  lrad  [N_EXP];
  logic [WGT_W-1:0]         wgt   [N_EXP];
  logic signed [ACC_W-1:0]  prod  [N_EXP];

  logic signed [ACC_W-1:0]  acc, num;
  logic [WSUM_W-1:0]        wsum, den;
  logic                     accept, div_busy, div_done;
  logic signed [LOG_W-1:0]  merged;

  assign pix[0] = px_short_i;
  assign pix[1] = px_mid_i;
  assign pix[2] = px_long_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_EXP; k++) ltime[k] <= '0;
    end else if (cfg_we_i && cfg_sel_i < 2'(N_EXP)) begin
      ltime[cfg_sel_i] <= cfg_data_i;
    end
  end

  for (genvar k = 0; k < N_EXP; k++) begin : g_lane
    hdr_lograd_lane u_lane (
      .pix_i  (pix[k]),
      .ltime_i(ltime[k]),
      .lrad_o (lrad[k]),
      .wgt_o  (wgt[k]),
      .prod_o (prod[k])
    );
  end

  assign acc  = prod[0] + prod[1] + prod[2];
  assign wsum = WSUM_W'(wgt[0]) + WSUM_W'(wgt[1]) + WSUM_W'(wgt[2]);
  // zero total weight: pass medium exposure through the divider as x/1
  assign num  = (wsum == '0) ? ACC_W'(lrad[1]) : acc;
  assign den  = (wsum == '0) ? WSUM_W'(1) : wsum;

  assign ready_o = !div_busy;
  assign accept  = in_valid_i && ready_o;

  hdr_seq_div #(.NUM_W(ACC_W), .DEN_W(WSUM_W), .Q_W(LOG_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .num_i  (num),
    .den_i  (den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (merged)
  );

  hdr_exp2 #(.LOG_W(LOG_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_exp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (div_done),
    .l_i   (merged),
    .v_o   (out_valid_o),
    .y_o   (out_rad_o)
  );

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);
  // R8
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
endmodule

// File: tb/hdr_radiance_merge_test.sv
module hdr_radiance_merge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [11:0] cfg_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  px_short_i = '0, px_mid_i = '0, px_long_i = '0;
  logic        ready_o, out_valid_o;
  logic [15:0] out_rad_o;

  int checks = 0;
  int fails = 0;
  int tt[3] = '{0, 0, 0};
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  hdr_radiance_merge uut (.*);

  localparam logic [23:0] VEC [8] = '{
    {8'd128, 8'd128, 8'd128}, {8'd40, 8'd100, 8'd200},
    {8'd10,  8'd60,  8'd250}, {8'd200, 8'd230, 8'd255},
    {8'd0,   8'd5,   8'd30},  {8'd127, 8'd128, 8'd126},
    {8'd1,   8'd254, 8'd0},   {8'd90,  8'd180, 8'd240}};

  function automatic int gcurve(int p);
    return (p < 192) ? 8 * p : 1536 + 16 * (p - 192);
  endfunction

  function automatic int hat(int p);
    return (p <= 127) ? p : 255 - p;
  endfunction

  function automatic int ref_rad(int p0, int p1, int p2);
    int pp[3] = '{p0, p1, p2};
    int s = 0, w = 0, l, n, m, v;
    for (int k = 0; k < 3; k++) begin
      s += hat(pp[k]) * (gcurve(pp[k]) - tt[k]);
      w += hat(pp[k]);
    end
    l = (w == 0) ? gcurve(p1) - tt[1] : s / w;
    n = l >>> 8;
    m = 256 + (l - 256 * n);
    if (n >= 16) return 65535;
    v = (n >= 0) ? (m << n) >> 8 : m >> (8 - n);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_time(int sel, int val);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_data_i = 12'(val);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (sel < 3) tt[sel] = val;
  endtask

  task automatic run_vec(int p0, int p1, int p2, string tag, bit poke = 1'b0);
    int exp, lat;
    exp = ref_rad(p0, p1, p2);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    px_short_i = 8'(p0); px_mid_i = 8'(p1); px_long_i = 8'(p2);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(!ready_o, {tag, " R8 ready low"}, int'(ready_o), 0);
    lat = 0;
    while (!out_valid_o && lat < 60) begin
      if (poke && lat == 3) begin
        px_short_i = 8'd255; px_mid_i = 8'd0; px_long_i = 8'd77;
        in_valid_i = 1'b1;
      end else in_valid_i = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    in_valid_i = 1'b0;
    chk(lat == 25, {tag, " R8 latency"}, lat, 25);
    chk(int'(out_rad_o) == exp, {tag, " R5 value"}, int'(out_rad_o), exp);
    @(negedge clk_i);
    chk(!out_valid_o, {tag, " R8 pulse"}, int'(out_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
    chk(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
    chk(out_rad_o == 16'd0, "R1 data", int'(out_rad_o), 0);
    rst_ni = 1'b1;
    // R1 / R2: zero times after reset, g(128)=1024 -> 16
    run_vec(128, 128, 128, "R1 reset times");
    chk(int'(out_rad_o) == 16, "R2 mid-scale", int'(out_rad_o), 16);
    // R3: load times, then a write to selector 3 must change nothing
    set_time(0, -512);
    set_time(1, 0);
    set_time(2, 512);
    set_time(3, 1000);
    for (int i = 0; i < 8; i++)
      run_vec(int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]),
              $sformatf("R4 vec%0d", i));
    // R5 negative quotient truncated toward zero
    run_vec(0, 5, 30, "R5 negative");
    // R2 upper knee segment, R6 fallback to medium exposure
    run_vec(255, 255, 255, "R6 all saturated");
    chk(int'(out_rad_o) == 992, "R2 knee", int'(out_rad_o), 992);
    set_time(1, -1024);
    run_vec(0, 0, 0, "R6 all black");
    chk(int'(out_rad_o) == 16, "R6 black value", int'(out_rad_o), 16);
    // R7 saturation
    set_time(1, -2048);
    run_vec(255, 255, 255, "R7 saturate");
    chk(int'(out_rad_o) == 65535, "R7 max", int'(out_rad_o), 65535);
    // R8 samples offered while busy are ignored
    set_time(1, 0);
    run_vec(40, 100, 200, "R8 busy ignore", 1'b1);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule